// File: doc/BRIEF.md
# Dual Capture Timer Unit

A 16-bit free-running up-counter advances on a prescaler enable while a run bit is set. Two 16-bit capture registers take a snapshot of the count either on chosen edges of two external inputs or when software issues a capture command. A one-cycle interrupt pulse marks each selected input edge.

A CPU reaches the block through a byte-wide register interface. Each capture register appears as a low-byte and a high-byte location. Software reads the low byte first and the high byte second. Between those two reads the register is frozen, so the two bytes always belong to the same 16-bit sample. A mode register holds the run bit, the capture-mode field and a write-only software-capture trigger.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset the counter, both capture registers, the run bit and the capture mode are zero, and `irq_o` is low. The mode register then reads 0x08.
- R2: The counter adds one on each clock where the run bit is 1 and `presc_en_i` is 1. It wraps from 0xFFFF to 0x0000 and holds its value otherwise.
- R3: Byte map: offset 0 is capture 0 low, 1 is capture 0 high, 2 is capture 1 low, 3 is capture 1 high, and 4 is the mode register. The mode register fields are bit 0 run, bits 2:1 capture mode, and bit 3 software capture. Bit 3 always reads 1. Other bits and offsets read 0. Read data is combinational from `bus_addr_i`.
- R4: Writes to offsets 0 to 3 are ignored.
- R5: A write to offset 4 with bit 3 at 0 copies the counter into capture 0, but only if the run bit was already 1 before that write. A write with bit 3 at 1 captures nothing.
- R6: In mode 01, a rising edge of `cap_a_i` captures into register 0 and a falling edge of `cap_a_i` captures into register 1.
- R7: In mode 10, a rising edge of `cap_a_i` captures into register 0 and a rising edge of `cap_b_i` captures into register 1. Falling edges do nothing.
- R8: In modes 00 and 11, input edges cause no capture and no interrupt.
- R9: Each selected edge gives a one-cycle `irq_o` pulse, even when the capture itself is blocked. The inputs pass through two synchronizer flops, so the pulse is high in the third cycle after the input changes.
- R10: A read of a register's low byte blocks every capture into that register, hardware or software, starting in the same cycle as the read. The block lasts until the read of its high byte, and the other register is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_en_i | input | 1 | Prescaler tick, counts when run bit is set |
| cap_a_i | input | 1 | External capture input A (asynchronous) |
| cap_b_i | input | 1 | External capture input B (asynchronous) |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe (drives the read lock) |
| bus_addr_i | input | 3 | Byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| irq_o | output | 1 | External interrupt pulse |

## Verification
The case that needs the most care is a low-byte read that falls on the same clock as a hardware capture edge into that register. The bench raises `cap_a_i` two cycles before it issues the low-byte read, so the synchronized edge lands exactly on the read cycle. It then checks three things: the low byte seen, the later high byte, and a full re-read all show the old sample, and the interrupt still pulses. A software capture issued while the register is locked is judged the same way, and so is a capture into the unlocked register during the lock.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_CAP  = 2;

  typedef enum logic [1:0] {
    CM_OFF    = 2'b00,
    CM_BOTH_A = 2'b01,
    CM_A_B    = 2'b10,
    CM_RSVD   = 2'b11
  } cap_mode_e;

  localparam int MODE_OFS  = 4;
  localparam int BIT_RUN   = 0;
  localparam int BIT_CM_LO = 1;
  localparam int BIT_SWCAP = 3;
endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= s;
    end
  end

  assign s      = sh_q[STAGES-1];
  assign rise_o = s & ~prev_q;
  assign fall_o = ~s & prev_q;
endmodule

// File: rtl/dct_cap_reg.sv
module dct_cap_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         rd_lo_i,
  input  logic         rd_hi_i,
  output logic [W-1:0] cap_o,
  output logic         lock_o
);
  logic [W-1:0] cap_q;
  logic         lock_q;
  logic         blocked;

  // low-byte read in this cycle already blocks, keeps the pair coherent
  assign blocked = lock_q | rd_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (rd_lo_i)      lock_q <= 1'b1;
      else if (rd_hi_i) lock_q <= 1'b0;
      if (load_i && !blocked) cap_q <= val_i;
    end
  end

  assign cap_o  = cap_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_WIDTH   = CNT_W,
  parameter int DATA_WIDTH  = BYTE_W,
  parameter int ADDR_WIDTH  = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  presc_en_i,
  input  logic                  cap_a_i,
  input  logic                  cap_b_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [ADDR_WIDTH-1:0] bus_addr_i,
  input  logic [DATA_WIDTH-1:0] bus_wdata_i,
  output logic [DATA_WIDTH-1:0] bus_rdata_o,
  output logic                  irq_o
);
  localparam int NIN = 2;

  logic                               run_q;
  cap_mode_e                          cmode_q;
  logic                               irq_q;
  logic                               inc;
  logic                               wr_mode;
  logic                               sw_req;
  logic                               sw_cap;
  logic                               mode_active;
  logic [CNT_WIDTH-1:0]               cnt;
  logic [NIN-1:0]                     in_vec, rise, fall;
  logic [N_CAP-1:0]                   trig, load, rd_lo, rd_hi, lock;
  logic [N_CAP-1:0][CNT_WIDTH-1:0]    cap_val;

  assign inc     = run_q & presc_en_i;
  assign wr_mode = bus_wr_i && (bus_addr_i == ADDR_WIDTH'(MODE_OFS));
  assign sw_req  = wr_mode && !bus_wdata_i[BIT_SWCAP];
  assign sw_cap  = sw_req && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cmode_q <= CM_OFF;
    end else if (wr_mode) begin
      run_q   <= bus_wdata_i[BIT_RUN];
      cmode_q <= cap_mode_e'(bus_wdata_i[BIT_CM_LO +: 2]);
    end
  end

  dct_counter #(.W(CNT_WIDTH)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .cnt_o (cnt)
  );

  assign in_vec = {cap_b_i, cap_a_i};

  for (genvar i = 0; i < NIN; i++) begin : g_sync
    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (in_vec[i]),
      .rise_o(rise[i]),
      .fall_o(fall[i])
    );
  end

  assign mode_active = (cmode_q == CM_BOTH_A) || (cmode_q == CM_A_B);

  always_comb begin
    trig = '0;
    unique case (cmode_q)
      CM_BOTH_A: trig = {fall[0], rise[0]};
      CM_A_B:    trig = {rise[1], rise[0]};
      default:   trig = '0;
    endcase
  end

  assign load = trig | {{(N_CAP-1){1'b0}}, sw_cap};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |trig;
  end

  assign irq_o = irq_q;

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    assign rd_lo[k] = bus_rd_i && (bus_addr_i == ADDR_WIDTH'(2*k));
    assign rd_hi[k] = bus_rd_i && (bus_addr_i == ADDR_WIDTH'(2*k+1));

    dct_cap_reg #(.W(CNT_WIDTH)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[k]),
      .val_i  (cnt),
      .rd_lo_i(rd_lo[k]),
      .rd_hi_i(rd_hi[k]),
      .cap_o  (cap_val[k]),
      .lock_o (lock[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < N_CAP; k++) begin
      if (bus_addr_i == ADDR_WIDTH'(2*k))
        bus_rdata_o = cap_val[k][DATA_WIDTH-1:0];
      if (bus_addr_i == ADDR_WIDTH'(2*k+1))
        bus_rdata_o = cap_val[k][CNT_WIDTH-1:DATA_WIDTH];
    end
    if (bus_addr_i == ADDR_WIDTH'(MODE_OFS)) begin
      bus_rdata_o[BIT_RUN]          = run_q;
      bus_rdata_o[BIT_CM_LO +: 2]   = cmode_q;
      bus_rdata_o[BIT_SWCAP]        = 1'b1;
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   inc_i,
  input logic [CW-1:0]          cnt_i,
  input logic [N_CAP-1:0][CW-1:0] cap_i,
  input logic [N_CAP-1:0]       lock_i,
  input logic                   mode_active_i,
  input logic                   sw_req_i,
  input logic                   irq_i
);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_i == CW'($past(cnt_i) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_i));

  // R8
  no_irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_active_i |=> !irq_i);

  // R8
  no_cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_active_i && !sw_req_i) |=> $stable(cap_i));

  for (genvar k = 0; k < N_CAP; k++) begin : g_lock
    // R10
    cap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[k] |=> $stable(cap_i[k]));
  end
endmodule

bind dual_capture_timer dct_checker #(.CW(CNT_WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inc_i        (inc),
  .cnt_i        (cnt),
  .cap_i        (cap_val),
  .lock_i       (lock),
  .mode_active_i(mode_active),
  .sw_req_i     (sw_req),
  .irq_i        (irq_o)
);

// File: tb/sim_dual_capture_timer.sv
module sim_dual_capture_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       presc_en_i = 1'b0;
  logic       cap_a_i = 1'b0;
  logic       cap_b_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  dual_capture_timer u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .presc_en_i (presc_en_i),
    .cap_a_i    (cap_a_i),
    .cap_b_i    (cap_b_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic rd16(input int idx, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(3'(2*idx), lo);
    bus_read(3'(2*idx+1), hi);
    v = {hi, lo};
  endtask

  task automatic tick(input int n);
    @(negedge clk_i);
    presc_en_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    presc_en_i = 1'b0;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (irq_o) c++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] v;
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    bus_read(3'd4, d);
    chk(d == 8'h08, "R1 mode", d, 8'h08);
    rd16(0, v); chk(v == 16'h0, "R1 cap0", v, 0);
    rd16(1, v); chk(v == 16'h0, "R1 cap1", v, 0);
    bus_read(3'd6, d);
    chk(d == 8'h00, "R3 unused offset", d, 0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    logic [7:0] d;
    bus_write(3'd4, 8'h09);
    bus_read(3'd4, d);
    chk(d == 8'h09, "R3 mode readback", d, 8'h09);
    tick(100);
    bus_write(3'd4, 8'h01);
    rd16(0, v); chk(v == 16'd100, "R2/R5 sw capture", v, 100);
    bus_write(3'd4, 8'h08);
    tick(10);
    bus_write(3'd4, 8'h00);
    rd16(0, v); chk(v == 16'd100, "R5 no capture when stopped", v, 100);
    bus_write(3'd4, 8'h09);
    bus_write(3'd4, 8'h01);
    rd16(0, v); chk(v == 16'd100, "R2 hold while stopped", v, 100);
    tick(5);
    bus_write(3'd4, 8'h09);
    rd16(0, v); chk(v == 16'd100, "R5 bit3=1 no capture", v, 100);
    bus_write(3'd4, 8'h01);
    rd16(0, v); chk(v == 16'd105, "R5 sw capture", v, 105);
  endtask

  task automatic t_readonly;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) bus_write(3'(a), 8'hAA);
    rd16(0, v); chk(v == 16'd105, "R4 cap0 unchanged", v, 105);
    rd16(1, v); chk(v == 16'd0, "R4 cap1 unchanged", v, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    tick(65535 - 105);
    bus_write(3'd4, 8'h01);
    rd16(0, v); chk(v == 16'hFFFF, "R2 reach max", v, 16'hFFFF);
    tick(1);
    bus_write(3'd4, 8'h01);
    rd16(0, v); chk(v == 16'h0000, "R2 wrap", v, 0);
  endtask

  task automatic t_mode01;
    logic [15:0] v;
    int c;
    tick(7);
    bus_write(3'd4, 8'h0B);
    @(negedge clk_i); cap_a_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(irq_o == 1'b1, "R9 irq timing", irq_o, 1);
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R9 irq one cycle", irq_o, 0);
    rd16(0, v); chk(v == 16'd7, "R6 rise to cap0", v, 7);
    tick(3);
    @(negedge clk_i); cap_a_i = 1'b0;
    count_irq(6, c);
    chk(c == 1, "R9 irq on fall", c, 1);
    rd16(1, v); chk(v == 16'd10, "R6 fall to cap1", v, 10);
    rd16(0, v); chk(v == 16'd7, "R6 cap0 kept", v, 7);
  endtask

  task automatic t_mode10;
    logic [15:0] v;
    int c;
    bus_write(3'd4, 8'h0D);
    tick(5);
    @(negedge clk_i); cap_b_i = 1'b1;
    count_irq(6, c);
    chk(c == 1, "R7 irq on B rise", c, 1);
    rd16(1, v); chk(v == 16'd15, "R7 B rise to cap1", v, 15);
    tick(2);
    @(negedge clk_i); cap_b_i = 1'b0;
    count_irq(6, c);
    chk(c == 0, "R7 B fall no irq", c, 0);
    rd16(1, v); chk(v == 16'd15, "R7 B fall ignored", v, 15);
    @(negedge clk_i); cap_a_i = 1'b1;
    count_irq(6, c);
    rd16(0, v); chk(v == 16'd17, "R7 A rise to cap0", v, 17);
    @(negedge clk_i); cap_a_i = 1'b0;
    count_irq(6, c);
    chk(c == 0, "R7 A fall no irq", c, 0);
    rd16(1, v); chk(v == 16'd15, "R7 A fall ignored", v, 15);
  endtask

  task automatic t_mode_off;
    logic [15:0] v0, v1;
    int c, c2;
    for (int m = 0; m < 2; m++) begin
      bus_write(3'd4, m == 0 ? 8'h09 : 8'h0F);
      tick(4);
      @(negedge clk_i); cap_a_i = 1'b1; cap_b_i = 1'b1;
      count_irq(6, c);
      @(negedge clk_i); cap_a_i = 1'b0; cap_b_i = 1'b0;
      count_irq(6, c2);
      chk(c + c2 == 0, "R8 no irq", c + c2, 0);
      rd16(0, v0); chk(v0 == 16'd17, "R8 cap0 unchanged", v0, 17);
      rd16(1, v1); chk(v1 == 16'd15, "R8 cap1 unchanged", v1, 15);
    end
  endtask

  task automatic t_lock;
    logic [7:0] d;
    logic [15:0] v;
    int c;
    // counter now 25
    bus_write(3'd4, 8'h0B);
    tick(16'h0123 - 25);
    bus_read(3'd0, d);
    chk(d == 8'h11, "R10 low read", d, 8'h11);
    @(negedge clk_i); cap_a_i = 1'b1;
    count_irq(6, c);
    chk(c == 1, "R9 irq while blocked", c, 1);
    bus_write(3'd4, 8'h03);
    @(negedge clk_i); cap_a_i = 1'b0;
    count_irq(6, c);
    rd16(1, v); chk(v == 16'h0123, "R10 other reg free", v, 16'h0123);
    bus_read(3'd1, d);
    chk(d == 8'h00, "R10 high coherent", d, 0);
    rd16(0, v); chk(v == 16'd17, "R10 blocked hw+sw", v, 17);
    bus_write(3'd4, 8'h03);
    rd16(0, v); chk(v == 16'h0123, "R10 unlocked sw", v, 16'h0123);
    // same-cycle: low read on the capture edge
    tick(16'h0456 - 16'h0123);
    @(negedge clk_i); cap_a_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_addr_i = 3'd0;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    chk(d == 8'h23, "R10 same-cycle low", d, 8'h23);
    chk(irq_o == 1'b1, "R9 irq same-cycle", irq_o, 1);
    bus_read(3'd1, d);
    chk(d == 8'h01, "R10 same-cycle high", d, 8'h01);
    rd16(0, v); chk(v == 16'h0123, "R10 same-cycle blocked", v, 16'h0123);
    @(negedge clk_i); cap_a_i = 1'b0;
    count_irq(6, c);
    rd16(1, v); chk(v == 16'h0456, "R6 fall after lock", v, 16'h0456);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_readonly();
    t_wrap();
    t_mode01();
    t_mode10();
    t_mode_off();
    t_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule